// File: doc/BRIEF.md
# Next-PC selection unit

This block picks the address the front end fetches next, once per cycle, from the redirect sources that can compete for it. Requests from the commit side and the backend (reset, trap, return from an environment call, mispredict correction, replay, pipeline flush) are merged with the prediction made for the instruction at the current fetch PC, and the default sequential step is used when nothing else applies. The selection is purely combinational; the fetch PC register, the predictor tables, the CSR file and fetch memory all live outside it.

Each predecoded instruction class has its own predictor and its own fallback. A jump-and-link-register uses the branch target buffer, a conditional branch uses the branch history table direction together with the predecoded branch target, and a return uses the return address stack. When its predictor has no valid answer the unit steps sequentially and leaves the correction to the backend. Trap vectors and return addresses are chosen by privilege mode and are always used word aligned.

Top module: `npc_select`

## Requirements
- R1: While `resetReq` is high, `nextPc` equals `bootAddr`, `reason` is 0 and `predTaken` is 0, whatever the other inputs are.
- R2: Otherwise, while `trapReq` is high, `nextPc` is `mtvec` (when `trapToSuper` is 0) or `stvec` (when 1) with bits [1:0] cleared, and `reason` is 1.
- R3: Otherwise, while `mretReq` or `sretReq` is high, `nextPc` is `mepc` with bits [1:0] cleared if `mretReq` is high, else `sepc` with bits [1:0] cleared; `reason` is 2.
- R4: Otherwise, while `mispValid` is high, `nextPc` is `mispPc` and `reason` is 3.
- R5: Otherwise, while `replayValid` is high, `nextPc` is `replayPc` and `reason` is 4.
- R6: Otherwise, while `flushValid` is high, `nextPc` is `flushPc` and `reason` is 5.
- R7: Otherwise, for `instrClass` 1 (JALR) with `btbValid` high, `nextPc` is `btbTarget`, `reason` is 6.
- R8: Otherwise, for `instrClass` 2 (conditional branch) with `bhtValid` and `bhtTaken` high, `nextPc` is `branchTarget`, `reason` is 6; a valid not-taken prediction gives the sequential address with `reason` 7.
- R9: Otherwise, for `instrClass` 3 (RET) with `rasValid` high, `nextPc` is `rasTarget`, `reason` is 6.
- R10: In every other case (class 0, or a predictor without a valid entry) `nextPc` is the sequential address and `reason` is 7.
- R11: The sequential address is `fetchPc`+2 when `isCompressed` and `fetchPc[1]` are both high, and `fetchPc`+4 otherwise.
- R12: `predTaken` is high exactly when `reason` is 6; `cfInstr` is high for any RET, for a JALR with `btbValid` and for a branch with `bhtValid`, independent of the priority outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| resetReq | input | 1 | Reset in progress, selects the boot address |
| bootAddr | input | PcW | Address fetched out of reset |
| fetchPc | input | PcW | Current fetch address |
| instrClass | input | 2 | Predecoded class: 0 other, 1 JALR, 2 branch, 3 RET |
| isCompressed | input | 1 | Instruction at fetchPc is 16 bits wide |
| btbValid | input | 1 | Branch target buffer hit |
| btbTarget | input | PcW | Target from the branch target buffer |
| bhtValid | input | 1 | Branch history table has a prediction |
| bhtTaken | input | 1 | Predicted direction is taken |
| branchTarget | input | PcW | Predecoded target of the conditional branch |
| rasValid | input | 1 | Return address stack has an entry |
| rasTarget | input | PcW | Top of the return address stack |
| mispValid | input | 1 | Backend mispredict redirect |
| mispPc | input | PcW | Corrected address from the backend |
| replayValid | input | 1 | Replay request |
| replayPc | input | PcW | Address to replay from |
| trapReq | input | 1 | Exception or interrupt taken at commit |
| trapToSuper | input | 1 | Trap goes to supervisor mode (0: machine mode) |
| mretReq | input | 1 | Machine-mode return |
| sretReq | input | 1 | Supervisor-mode return |
| flushValid | input | 1 | Pipeline flush |
| flushPc | input | PcW | Restart address after the flush |
| mtvec | input | PcW | Machine trap vector base |
| stvec | input | PcW | Supervisor trap vector base |
| mepc | input | PcW | Machine exception PC |
| sepc | input | PcW | Supervisor exception PC |
| nextPc | output | PcW | Selected next fetch address |
| reason | output | 3 | Winning source code (0..7, see requirements) |
| predTaken | output | 1 | Next PC comes from a taken prediction |
| cfInstr | output | 1 | Instruction is treated as control flow |

## Verification
On every evaluation the assertions check the reset override, the alignment of trap and return targets, that a sequential step is always 2 or 4 bytes, that the taken flag tracks the prediction code, and that a RET is always marked as control flow. The full priority order, the choice between machine and supervisor vectors and return addresses, and each class's fallback when its predictor is empty can only be shown by the bench sweep, which drives every combination of request lines, class, predictor validity, compressed flag and PC half-word position and compares against an independently computed result.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [2:0] {
    RSN_BOOT   = 3'd0,
    RSN_TRAP   = 3'd1,
    RSN_ERET   = 3'd2,
    RSN_MISP   = 3'd3,
    RSN_REPLAY = 3'd4,
    RSN_FLUSH  = 3'd5,
    RSN_PRED   = 3'd6,
    RSN_SEQ    = 3'd7
  } reason_e;

  typedef enum logic [1:0] {
    IC_OTHER  = 2'd0,
    IC_JALR   = 2'd1,
    IC_BRANCH = 2'd2,
    IC_RET    = 2'd3
  } iclass_e;

  typedef enum logic [1:0] {
    PS_BTB = 2'd0,
    PS_BHT = 2'd1,
    PS_RAS = 2'd2
  } predsrc_e;

  // One-hot source selects plus mode qualifiers, control -> datapath
  typedef struct packed {
    logic     selBoot;
    logic     selTrap;
    logic     selEret;
    logic     selMisp;
    logic     selReplay;
    logic     selFlush;
    logic     selPred;
    logic     selSeq;
    logic     trapSuper;
    logic     eretSuper;
    predsrc_e predSrc;
  } strobe_t;

endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic       resetReq,
  input  logic [1:0] instrClass,
  input  logic       btbValid,
  input  logic       bhtValid,
  input  logic       bhtTaken,
  input  logic       rasValid,
  input  logic       mispValid,
  input  logic       replayValid,
  input  logic       trapReq,
  input  logic       trapToSuper,
  input  logic       mretReq,
  input  logic       sretReq,
  input  logic       flushValid,
  output strobe_t    strobes,
  output logic [2:0] reason,
  output logic       predTaken,
  output logic       cfInstr
);

  logic     predHit;
  predsrc_e predSrc;
  reason_e  rsn;

  // Per-class predictor lookup and control-flow marking
  always_comb begin
    predHit = 1'b0;
    predSrc = PS_BTB;
    cfInstr = 1'b0;
    unique case (iclass_e'(instrClass))
      IC_JALR: begin
        predHit = btbValid;
        predSrc = PS_BTB;
        cfInstr = btbValid;
      end
      IC_BRANCH: begin
        predHit = bhtValid & bhtTaken;
        predSrc = PS_BHT;
        cfInstr = bhtValid;
      end
      IC_RET: begin
        predHit = rasValid;
        predSrc = PS_RAS;
        cfInstr = 1'b1;
      end
      default: ;
    endcase
  end

  // Fixed-priority source arbitration
  always_comb begin
    if (resetReq)                rsn = RSN_BOOT;
    else if (trapReq)            rsn = RSN_TRAP;
    else if (mretReq | sretReq)  rsn = RSN_ERET;
    else if (mispValid)          rsn = RSN_MISP;
    else if (replayValid)        rsn = RSN_REPLAY;
    else if (flushValid)         rsn = RSN_FLUSH;
    else if (predHit)            rsn = RSN_PRED;
    else                         rsn = RSN_SEQ;
  end

  always_comb begin
    strobes           = '0;
    strobes.selBoot   = (rsn == RSN_BOOT);
    strobes.selTrap   = (rsn == RSN_TRAP);
    strobes.selEret   = (rsn == RSN_ERET);
    strobes.selMisp   = (rsn == RSN_MISP);
    strobes.selReplay = (rsn == RSN_REPLAY);
    strobes.selFlush  = (rsn == RSN_FLUSH);
    strobes.selPred   = (rsn == RSN_PRED);
    strobes.selSeq    = (rsn == RSN_SEQ);
    strobes.trapSuper = trapToSuper;
    strobes.eretSuper = ~mretReq;
    strobes.predSrc   = predSrc;
  end

  assign reason    = rsn;
  assign predTaken = (rsn == RSN_PRED);

endmodule

// File: rtl/npc_dp.sv
module npc_dp
  import npc_pkg::*;
#(
  parameter int PcW = 32
) (
  input  strobe_t          strobes,
  input  logic [PcW-1:0]   bootAddr,
  input  logic [PcW-1:0]   fetchPc,
  input  logic             isCompressed,
  input  logic [PcW-1:0]   btbTarget,
  input  logic [PcW-1:0]   branchTarget,
  input  logic [PcW-1:0]   rasTarget,
  input  logic [PcW-1:0]   mispPc,
  input  logic [PcW-1:0]   replayPc,
  input  logic [PcW-1:0]   flushPc,
  input  logic [PcW-1:0]   mtvec,
  input  logic [PcW-1:0]   stvec,
  input  logic [PcW-1:0]   mepc,
  input  logic [PcW-1:0]   sepc,
  output logic [PcW-1:0]   nextPc
);

  localparam logic [PcW-1:0] AlignMask = ~PcW'(3);
  localparam logic [PcW-1:0] StepHalf  = PcW'(2);
  localparam logic [PcW-1:0] StepWord  = PcW'(4);

  logic [PcW-1:0] seqPc;
  logic [PcW-1:0] trapPc;
  logic [PcW-1:0] eretPc;
  logic [PcW-1:0] predPc;

  assign seqPc  = fetchPc + ((isCompressed & fetchPc[1]) ? StepHalf : StepWord);
  assign trapPc = (strobes.trapSuper ? stvec : mtvec) & AlignMask;
  assign eretPc = (strobes.eretSuper ? sepc : mepc) & AlignMask;

  always_comb begin
    unique case (strobes.predSrc)
      PS_BHT:  predPc = branchTarget;
      PS_RAS:  predPc = rasTarget;
      default: predPc = btbTarget;
    endcase
  end

  always_comb begin
    nextPc = seqPc;
    if (strobes.selBoot)        nextPc = bootAddr;
    else if (strobes.selTrap)   nextPc = trapPc;
    else if (strobes.selEret)   nextPc = eretPc;
    else if (strobes.selMisp)   nextPc = mispPc;
    else if (strobes.selReplay) nextPc = replayPc;
    else if (strobes.selFlush)  nextPc = flushPc;
    else if (strobes.selPred)   nextPc = predPc;
  end

endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int PcW = 32
) (
  input  logic             resetReq,
  input  logic [PcW-1:0]   bootAddr,
  input  logic [PcW-1:0]   fetchPc,
  input  logic [1:0]       instrClass,
  input  logic             isCompressed,
  input  logic             btbValid,
  input  logic [PcW-1:0]   btbTarget,
  input  logic             bhtValid,
  input  logic             bhtTaken,
  input  logic [PcW-1:0]   branchTarget,
  input  logic             rasValid,
  input  logic [PcW-1:0]   rasTarget,
  input  logic             mispValid,
  input  logic [PcW-1:0]   mispPc,
  input  logic             replayValid,
  input  logic [PcW-1:0]   replayPc,
  input  logic             trapReq,
  input  logic             trapToSuper,
  input  logic             mretReq,
  input  logic             sretReq,
  input  logic             flushValid,
  input  logic [PcW-1:0]   flushPc,
  input  logic [PcW-1:0]   mtvec,
  input  logic [PcW-1:0]   stvec,
  input  logic [PcW-1:0]   mepc,
  input  logic [PcW-1:0]   sepc,
  output logic [PcW-1:0]   nextPc,
  output logic [2:0]       reason,
  output logic             predTaken,
  output logic             cfInstr
);

  strobe_t strobes;

  npc_ctrl ctrlI (
    .resetReq    (resetReq),
    .instrClass  (instrClass),
    .btbValid    (btbValid),
    .bhtValid    (bhtValid),
    .bhtTaken    (bhtTaken),
    .rasValid    (rasValid),
    .mispValid   (mispValid),
    .replayValid (replayValid),
    .trapReq     (trapReq),
    .trapToSuper (trapToSuper),
    .mretReq     (mretReq),
    .sretReq     (sretReq),
    .flushValid  (flushValid),
    .strobes     (strobes),
    .reason      (reason),
    .predTaken   (predTaken),
    .cfInstr     (cfInstr)
  );

  npc_dp #(.PcW(PcW)) dpI (
    .strobes      (strobes),
    .bootAddr     (bootAddr),
    .fetchPc      (fetchPc),
    .isCompressed (isCompressed),
    .btbTarget    (btbTarget),
    .branchTarget (branchTarget),
    .rasTarget    (rasTarget),
    .mispPc       (mispPc),
    .replayPc     (replayPc),
    .flushPc      (flushPc),
    .mtvec        (mtvec),
    .stvec        (stvec),
    .mepc         (mepc),
    .sepc         (sepc),
    .nextPc       (nextPc)
  );

endmodule

// File: rtl/npc_select_chk.sv
module npc_select_chk #(
  parameter int PcW = 32
) (
  input logic             resetReq,
  input logic [PcW-1:0]   bootAddr,
  input logic [PcW-1:0]   fetchPc,
  input logic [1:0]       instrClass,
  input logic [PcW-1:0]   nextPc,
  input logic [2:0]       reason,
  input logic             predTaken,
  input logic             cfInstr
);

  logic [PcW-1:0] stepSize;
  assign stepSize = nextPc - fetchPc;

  always_comb begin
    if (resetReq) begin
      AST_RESET_BOOT: assert (nextPc == bootAddr && reason == 3'd0 && !predTaken)
        else $error("boot address not selected under reset"); // R1
    end
    if (reason == 3'd1) begin
      AST_TRAP_ALIGNED: assert (nextPc[1:0] == 2'b00)
        else $error("trap target not aligned"); // R2
    end
    if (reason == 3'd2) begin
      AST_ERET_ALIGNED: assert (nextPc[1:0] == 2'b00)
        else $error("return target not aligned"); // R3
    end
    if (reason == 3'd7) begin
      AST_SEQ_STEP: assert (stepSize == PcW'(2) || stepSize == PcW'(4))
        else $error("sequential step neither 2 nor 4"); // R11
    end
    AST_TAKEN_CODE: assert (predTaken == (reason == 3'd6))
      else $error("taken flag disagrees with reason"); // R12
    if (instrClass == 2'd3) begin
      AST_RET_IS_CF: assert (cfInstr)
        else $error("return not marked as control flow"); // R12
    end
  end

endmodule

bind npc_select npc_select_chk #(.PcW(PcW)) chkI (
  .resetReq   (resetReq),
  .bootAddr   (bootAddr),
  .fetchPc    (fetchPc),
  .instrClass (instrClass),
  .nextPc     (nextPc),
  .reason     (reason),
  .predTaken  (predTaken),
  .cfInstr    (cfInstr)
);

// File: tb/npc_select_test.sv
module npc_select_test;

  localparam int PcW       = 32;
  localparam int ClkPeriod = 10;
  localparam int WatchdogCycles = 100000;

  logic clk = 1'b0;
  always #(ClkPeriod / 2) clk = ~clk;

  logic             resetReq, isCompressed;
  logic [PcW-1:0]   bootAddr, fetchPc, btbTarget, branchTarget, rasTarget;
  logic [PcW-1:0]   mispPc, replayPc, flushPc, mtvec, stvec, mepc, sepc;
  logic [1:0]       instrClass;
  logic             btbValid, bhtValid, bhtTaken, rasValid;
  logic             mispValid, replayValid, trapReq, trapToSuper;
  logic             mretReq, sretReq, flushValid;
  logic [PcW-1:0]   nextPc;
  logic [2:0]       reason;
  logic             predTaken, cfInstr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  npc_select #(.PcW(PcW)) uut (
    .resetReq(resetReq), .bootAddr(bootAddr), .fetchPc(fetchPc),
    .instrClass(instrClass), .isCompressed(isCompressed),
    .btbValid(btbValid), .btbTarget(btbTarget),
    .bhtValid(bhtValid), .bhtTaken(bhtTaken), .branchTarget(branchTarget),
    .rasValid(rasValid), .rasTarget(rasTarget),
    .mispValid(mispValid), .mispPc(mispPc),
    .replayValid(replayValid), .replayPc(replayPc),
    .trapReq(trapReq), .trapToSuper(trapToSuper),
    .mretReq(mretReq), .sretReq(sretReq),
    .flushValid(flushValid), .flushPc(flushPc),
    .mtvec(mtvec), .stvec(stvec), .mepc(mepc), .sepc(sepc),
    .nextPc(nextPc), .reason(reason), .predTaken(predTaken), .cfInstr(cfInstr)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (WatchdogCycles) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
      summary();
      $finish;
    end
  end

  initial begin
    bootAddr     = 32'h8000_0000;
    btbTarget    = 32'h0000_5000;
    branchTarget = 32'h0000_6000;
    rasTarget    = 32'h0000_7000;
    mispPc       = 32'h0000_9000;
    replayPc     = 32'h0000_A000;
    flushPc      = 32'h0000_B000;
    mtvec        = 32'h0000_1003;
    stvec        = 32'h0000_2001;
    mepc         = 32'h0000_3002;
    sepc         = 32'h0000_4003;

    for (int v = 0; v < 65536; v++) begin
      logic [PcW-1:0] expPc, seq;
      logic [2:0]     expRsn;
      logic           expCf;
      string          tag;

      resetReq     = v[0];
      trapReq      = v[1];
      mretReq      = v[2];
      sretReq      = v[3];
      mispValid    = v[4];
      replayValid  = v[5];
      flushValid   = v[6];
      instrClass   = v[8:7];
      btbValid     = v[9];
      bhtValid     = v[10];
      bhtTaken     = v[11];
      rasValid     = v[12];
      isCompressed = v[13];
      trapToSuper  = v[14];
      fetchPc      = v[15] ? 32'h0000_0102 : 32'h0000_0100;
      #1;

      // R11: sequential step
      seq = (isCompressed && fetchPc[1]) ? fetchPc + 2 : fetchPc + 4;

      if (resetReq) begin
        expPc = bootAddr; expRsn = 3'd0; tag = "R1";
      end else if (trapReq) begin
        expPc = trapToSuper ? 32'h0000_2000 : 32'h0000_1000; expRsn = 3'd1; tag = "R2";
      end else if (mretReq) begin
        expPc = 32'h0000_3000; expRsn = 3'd2; tag = "R3";
      end else if (sretReq) begin
        expPc = 32'h0000_4000; expRsn = 3'd2; tag = "R3";
      end else if (mispValid) begin
        expPc = mispPc; expRsn = 3'd3; tag = "R4";
      end else if (replayValid) begin
        expPc = replayPc; expRsn = 3'd4; tag = "R5";
      end else if (flushValid) begin
        expPc = flushPc; expRsn = 3'd5; tag = "R6";
      end else if (instrClass == 2'd1 && btbValid) begin
        expPc = btbTarget; expRsn = 3'd6; tag = "R7";
      end else if (instrClass == 2'd2 && bhtValid && bhtTaken) begin
        expPc = branchTarget; expRsn = 3'd6; tag = "R8";
      end else if (instrClass == 2'd3 && rasValid) begin
        expPc = rasTarget; expRsn = 3'd6; tag = "R9";
      end else begin
        expPc = seq; expRsn = 3'd7;
        tag = (instrClass == 2'd2 && bhtValid) ? "R8" : "R10";
      end

      checks++;
      if (nextPc !== expPc || reason !== expRsn) begin
        errors++;
        $display("FAIL %s (R11 seq) vec=%0h: actual pc=%h rsn=%0d expected pc=%h rsn=%0d",
                 tag, v, nextPc, reason, expPc, expRsn);
      end

      // R12: taken flag and control-flow marking
      expCf = (instrClass == 2'd3) ||
              (instrClass == 2'd1 && btbValid) ||
              (instrClass == 2'd2 && bhtValid);
      checks++;
      if (predTaken !== (expRsn == 3'd6) || cfInstr !== expCf) begin
        errors++;
        $display("FAIL R12 vec=%0h: actual taken=%b cf=%b expected taken=%b cf=%b",
                 v, predTaken, cfInstr, (expRsn == 3'd6), expCf);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule